// File: doc/BRIEF.md
# Level-Triggered DMA Request Sequencer

This block is one DMA channel that an external agent starts by pulling an active-low request line low. Software first loads a transfer count and the source and destination word addresses, then writes the enable strobe. On every rising clock edge after that strobe, the controller looks at the request line, but only while acceptance is open. A low level seen on such an edge becomes a pending request inside the controller. One cycle later the pending request turns into an activation. The controller then asks for the bus and, once granted, runs one dual-address transfer: a read from the source, followed by a write of the read data to the destination.

Acceptance closes as soon as a request is latched. It reopens by itself on the cycle after the destination write completes, so a line held low gives a steady train of single transfers. Each finished write lowers the count by one and moves both addresses forward by one word. When the count reaches zero, the channel switches itself off and pulses a done flag.

Top module: `lvl_dma_seq`

## Requirements
- R1: While reset is asserted, and right after it, the channel is disabled, nothing is pending, and `bus_req`, `bus_cyc` and `done` are low.
- R2: A low `req_n` is ignored while the channel is disabled, including the cycle in which `en_wr` is high. The first edge that can latch a request is the one after the edge that samples `en_wr`.
- R3: A latched request is cleared at the next edge, which starts activation. `bus_req` rises two edges after the latch, so with an immediate grant `bus_cyc` rises three edges after the latch.
- R4: Each transfer is a read phase (`bus_cyc`=1, `bus_we`=0, `bus_addr`=source) followed by a write phase (`bus_cyc`=1, `bus_we`=1, `bus_addr`=destination, `bus_wdata`=the data returned in the read). Each phase holds its address and direction until `bus_rdy` is high at an edge.
- R5: From the latching edge until the write phase completes, `req_n` is not sampled. One accepted request yields exactly one transfer.
- R6: With `req_n` held low, a grant delay of G cycles and a ready delay of W cycles per phase, completed writes are spaced exactly 6+G+2W cycles apart.
- R7: Transfer k (counted from 0) reads source+2k and writes destination+2k, with addresses in bytes and one word being 2 bytes.
- R8: Each completed write decrements the count. The write that brings it to zero disables the channel and raises `done` for exactly one cycle, after which a low `req_n` starts nothing.
- R9: An `en_wr` while the effective count is zero is ignored. Here the effective count is `ld_cnt` if `ld` is high in the same cycle, otherwise the stored count. An `ld` while the channel is enabled changes neither the count nor the addresses.
- R10: `bus_req` stays high from the bus-request phase through the end of the write, `bus_cyc` is high only while `bus_req` is high, and `bus_req` drops on the edge at which the write completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_wr | input | 1 | Register-write strobe that enables the channel |
| ld | input | 1 | Loads count and addresses while disabled |
| ld_cnt | input | CW | Transfer count to load |
| ld_src | input | AW | Source byte address to load |
| ld_dst | input | AW | Destination byte address to load |
| req_n | input | 1 | Active-low level-sensitive transfer request |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus grant |
| bus_cyc | output | 1 | A bus cycle is in progress |
| bus_we | output | 1 | 1 = write phase, 0 = read phase |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, captured when `bus_rdy` is high in the read phase |
| bus_rdy | input | 1 | Completion of the current bus phase |
| done | output | 1 | One-cycle pulse when the count is exhausted |

## Verification
Some properties are checked on every cycle. The channel must be enabled before a request can latch, and a pending request lasts only one cycle. `bus_req` may rise only two edges after a latch. A write phase must follow a completed read, and each phase stays stable until ready. `bus_cyc` must sit inside `bus_req`, and the bus must be released after the write. `done` is a lone pulse that leaves the channel disabled. The bench scenarios cover everything else. That includes the exact enable-to-request latency, the addresses and data of each transfer, and the cycle spacing of back-to-back transfers swept over counts and handshake delays. It also covers the ignored cases: requests before enabling, requests during a transfer, enabling with a zero count, and loads while running.

// File: rtl/lvl_dma_pkg.sv
package lvl_dma_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACT,
        ST_BREQ,
        ST_RD,
        ST_WR
    } seq_st_e;
endpackage

// File: rtl/lvl_dma_regs.sv
// Channel enable, transfer count and address registers.
module lvl_dma_regs #(
    parameter int AW   = 16,
    parameter int CW   = 8,
    parameter int STEP = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_wr,
    input  logic          ld,
    input  logic [CW-1:0] ld_cnt,
    input  logic [AW-1:0] ld_src,
    input  logic [AW-1:0] ld_dst,
    input  logic          xfer_done,
    output logic          en,
    output logic [AW-1:0] src,
    output logic [AW-1:0] dst,
    output logic          done
);
    typedef struct packed {
        logic          en;
        logic [CW-1:0] cnt;
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic          done;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        logic [CW-1:0] eff_cnt;
        r_d      = r_q;
        r_d.done = 1'b0;
        eff_cnt  = ld ? ld_cnt : r_q.cnt;
        if (!r_q.en) begin
            if (ld) begin
                r_d.cnt = ld_cnt;
                r_d.src = ld_src;
                r_d.dst = ld_dst;
            end
            if (en_wr && (eff_cnt != '0)) begin
                r_d.en = 1'b1;
            end
        end else if (xfer_done) begin
            r_d.cnt = r_q.cnt - 1'b1;
            r_d.src = r_q.src + AW'(STEP);
            r_d.dst = r_q.dst + AW'(STEP);
            if (r_q.cnt == CW'(1)) begin
                r_d.en   = 1'b0;
                r_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign en   = r_q.en;
    assign src  = r_q.src;
    assign dst  = r_q.dst;
    assign done = r_q.done;
endmodule

// File: rtl/lvl_dma_accept.sv
// Level sampler of the request line with a one-deep pending latch.
module lvl_dma_accept (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic open_win,
    input  logic req_n,
    input  logic clr,
    output logic pend
);
    typedef struct packed {
        logic pend;
    } acc_t;

    acc_t a_d, a_q;

    always_comb begin
        a_d = a_q;
        if (clr) begin
            a_d.pend = 1'b0;
        end else if (en && open_win && !a_q.pend && !req_n) begin
            a_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

    assign pend = a_q.pend;
endmodule

// File: rtl/lvl_dma_fsm.sv
// Activation and dual-address transfer sequencer.
module lvl_dma_fsm
    import lvl_dma_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pend,
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] dst,
    input  logic          bus_gnt,
    input  logic          bus_rdy,
    input  logic [DW-1:0] bus_rdata,
    output logic          clr,
    output logic          idle,
    output logic          wr_done,
    output logic          bus_req,
    output logic          bus_cyc,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata
);
    typedef struct packed {
        seq_st_e       st;
        logic [DW-1:0] data;
    } fsm_t;

    fsm_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        unique case (f_q.st)
            ST_IDLE: if (pend) f_d.st = ST_ACT;
            ST_ACT:  f_d.st = ST_BREQ;
            ST_BREQ: if (bus_gnt) f_d.st = ST_RD;
            ST_RD: begin
                if (bus_rdy) begin
                    f_d.data = bus_rdata;
                    f_d.st   = ST_WR;
                end
            end
            ST_WR:   if (bus_rdy) f_d.st = ST_IDLE;
            default: f_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '{st: ST_IDLE, data: '0};
        else        f_q <= f_d;
    end

    assign idle      = (f_q.st == ST_IDLE);
    assign clr       = idle && pend;
    assign wr_done   = (f_q.st == ST_WR) && bus_rdy;
    assign bus_cyc   = (f_q.st == ST_RD) || (f_q.st == ST_WR);
    assign bus_req   = bus_cyc || (f_q.st == ST_BREQ);
    assign bus_we    = (f_q.st == ST_WR);
    assign bus_addr  = bus_we ? dst : src;
    assign bus_wdata = f_q.data;
endmodule

// File: rtl/lvl_dma_seq.sv
module lvl_dma_seq #(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_wr,
    input  logic          ld,
    input  logic [CW-1:0] ld_cnt,
    input  logic [AW-1:0] ld_src,
    input  logic [AW-1:0] ld_dst,
    input  logic          req_n,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic          bus_cyc,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_rdy,
    output logic          done
);
    localparam int STEP = DW / 8;

    logic          en_w, pend_w, clr_w, idle_w, wrdone_w;
    logic [AW-1:0] src_w, dst_w;

    lvl_dma_regs #(.AW(AW), .CW(CW), .STEP(STEP)) u_regs (
        .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .ld(ld),
        .ld_cnt(ld_cnt), .ld_src(ld_src), .ld_dst(ld_dst),
        .xfer_done(wrdone_w), .en(en_w), .src(src_w), .dst(dst_w), .done(done)
    );

    lvl_dma_accept u_acc (
        .clk(clk), .rst_n(rst_n), .en(en_w), .open_win(idle_w),
        .req_n(req_n), .clr(clr_w), .pend(pend_w)
    );

    lvl_dma_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .pend(pend_w), .src(src_w), .dst(dst_w),
        .bus_gnt(bus_gnt), .bus_rdy(bus_rdy), .bus_rdata(bus_rdata),
        .clr(clr_w), .idle(idle_w), .wr_done(wrdone_w),
        .bus_req(bus_req), .bus_cyc(bus_cyc), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata)
    );
endmodule

// File: rtl/lvl_dma_seq_chk.sv
module lvl_dma_seq_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic          pend,
    input logic          bus_req,
    input logic          bus_cyc,
    input logic          bus_we,
    input logic          bus_rdy,
    input logic          done,
    input logic [AW-1:0] bus_addr
);
    assert_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> $past(en));

    assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> $past(pend, 2));

    assert_read_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && bus_we && !$past(bus_cyc && bus_we)) |-> $past(bus_cyc && !bus_we && bus_rdy));

    assert_phase_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && !bus_rdy) |=> (bus_cyc && $stable(bus_addr) && $stable(bus_we)));

    assert_one_shot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pend |=> !pend);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !en);

    assert_cyc_in_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc |-> bus_req);

    assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && bus_we && bus_rdy) |=> !bus_req);
endmodule

bind lvl_dma_seq lvl_dma_seq_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en_w), .pend(pend_w),
    .bus_req(bus_req), .bus_cyc(bus_cyc), .bus_we(bus_we),
    .bus_rdy(bus_rdy), .done(done), .bus_addr(bus_addr)
);

// File: tb/lvl_dma_seq_tb_top.sv
module lvl_dma_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int CW = 8;
    localparam int STEP = DW / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en_wr = 1'b0, ld = 1'b0, req_n = 1'b1;
    logic [CW-1:0] ld_cnt = '0;
    logic [AW-1:0] ld_src = '0, ld_dst = '0;
    logic          bus_req, bus_cyc, bus_we, done;
    logic          bus_gnt = 1'b0, bus_rdy = 1'b0;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    lvl_dma_seq #(.AW(AW), .DW(DW), .CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .ld(ld), .ld_cnt(ld_cnt),
        .ld_src(ld_src), .ld_dst(ld_dst), .req_n(req_n), .bus_req(bus_req),
        .bus_gnt(bus_gnt), .bus_cyc(bus_cyc), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rdy(bus_rdy), .done(done)
    );

    function automatic logic [DW-1:0] mem_val(input logic [AW-1:0] a);
        return DW'(a) ^ DW'(16'h5A3C);
    endfunction

    assign bus_rdata = mem_val(bus_addr);

    // run context written by the stimulus process
    int            run_tag = 0;
    int            gl = 0, rl = 0;
    logic [AW-1:0] exp_src = '0, exp_dst = '0;
    int            period_exp = 0;

    // monitor / bus responder state
    int mchk = 0, merr = 0;
    int seen_tag = 0, cyc = 0, gw = 0, rw = 0;
    int widx = 0, rdidx = 0, last_wr = 0, done_cnt = 0;
    bit breq_seen = 0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (seen_tag != run_tag) begin
            seen_tag = run_tag;
            widx = 0; rdidx = 0; done_cnt = 0; breq_seen = 0;
        end
        if (done) done_cnt = done_cnt + 1;
        if (bus_req) breq_seen = 1;
        if (bus_req && !bus_cyc) begin
            bus_gnt = (gw >= gl);
            gw = gw + 1;
        end else begin
            bus_gnt = 1'b0;
            gw = 0;
        end
        if (bus_cyc) begin
            if (bus_rdy) rw = 0;
            bus_rdy = (rw >= rl);
            rw = rw + 1;
            if (bus_rdy) begin
                if (!bus_we) begin
                    mchk = mchk + 1;   // R4 R7 read address
                    if (bus_addr != exp_src + AW'(rdidx * STEP)) begin
                        merr = merr + 1;
                        $display("FAIL R7 read addr act=%0h exp=%0h", bus_addr, exp_src + AW'(rdidx * STEP));
                    end
                    rdidx = rdidx + 1;
                end else begin
                    mchk = mchk + 1;   // R7 write address
                    if (bus_addr != exp_dst + AW'(widx * STEP)) begin
                        merr = merr + 1;
                        $display("FAIL R7 write addr act=%0h exp=%0h", bus_addr, exp_dst + AW'(widx * STEP));
                    end
                    mchk = mchk + 1;   // R4 write data equals read data
                    if (bus_wdata != mem_val(exp_src + AW'(widx * STEP))) begin
                        merr = merr + 1;
                        $display("FAIL R4 wdata act=%0h exp=%0h", bus_wdata, mem_val(exp_src + AW'(widx * STEP)));
                    end
                    if (widx > 0 && period_exp > 0) begin
                        mchk = mchk + 1;   // R6 spacing
                        if (cyc - last_wr != period_exp) begin
                            merr = merr + 1;
                            $display("FAIL R6 spacing act=%0d exp=%0d", cyc - last_wr, period_exp);
                        end
                    end
                    last_wr = cyc;
                    widx = widx + 1;
                end
            end
        end else begin
            bus_rdy = 1'b0;
            rw = 0;
        end
    end

    int nchk = 0, nerr = 0;
    bit reported = 0;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        nchk = nchk + 1;
        if (!ok) begin
            nerr = nerr + 1;
            $display("FAIL %s act=%0d exp=%0d", rq, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("  CHECKS %0d ERRORS %0d", nchk + mchk, nerr + merr);
            $finish;
        end
    endtask

    task automatic new_run(input logic [AW-1:0] s, input logic [AW-1:0] d, input int p);
        @(posedge clk);
        exp_src = s; exp_dst = d; period_exp = p;
        run_tag = run_tag + 1;
        @(negedge clk);
    endtask

    task automatic load(input int c, input logic [AW-1:0] s, input logic [AW-1:0] d);
        @(negedge clk);
        ld = 1'b1; ld_cnt = CW'(c); ld_src = s; ld_dst = d;
        @(negedge clk);
        ld = 1'b0;
    endtask

    task automatic enable();
        @(negedge clk);
        en_wr = 1'b1;
        @(negedge clk);
        en_wr = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 600 && done_cnt == 0; i++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        nerr = nerr + 1;
        $display("FAIL watchdog act=1 exp=0");
        report();
    end

    initial begin
        int lat;
        // R1 reset state
        idle_cycles(3);
        chk(!bus_req && !bus_cyc && !done, "R1 reset outputs", {bus_req, bus_cyc, done}, 0);
        rst_n = 1'b1;
        idle_cycles(2);
        chk(!bus_req && !bus_cyc && !done, "R1 after reset", {bus_req, bus_cyc, done}, 0);

        // R2 request before enabling is ignored
        new_run('0, '0, 0);
        req_n = 1'b0;
        idle_cycles(10);
        chk(!breq_seen, "R2 disabled ignores req", breq_seen, 0);

        // R9 enable with zero count ignored
        new_run('0, '0, 0);
        load(0, 16'h0100, 16'h0200);
        enable();
        idle_cycles(10);
        chk(!breq_seen && done_cnt == 0, "R9 zero count enable", breq_seen + done_cnt, 0);

        // R2 R3 latency from enable with immediate grant
        gl = 0; rl = 0;
        new_run(16'h0040, 16'h0800, 0);
        load(1, 16'h0040, 16'h0800);
        enable();
        lat = 0;
        while (!bus_req && lat < 20) begin @(negedge clk); lat++; end
        chk(lat == 3, "R2 R3 enable to bus_req", lat, 3);
        wait_done();
        chk(widx == 1, "R8 single transfer count", widx, 1);
        chk(done_cnt == 1, "R8 done pulse once", done_cnt, 1);

        // R8 further requests ignored after done
        new_run('0, '0, 0);
        idle_cycles(12);
        chk(!breq_seen, "R8 disabled after done", breq_seen, 0);

        // R6 R7 R10 sweep of count and handshake delays, request held low
        for (int c = 1; c <= 4; c++) begin
            for (int g = 0; g <= 2; g++) begin
                for (int w = 0; w <= 2; w++) begin
                    logic [AW-1:0] s, d;
                    s = AW'(16'h1000 + c * 16'h40 + g * 16'h8);
                    d = AW'(16'h8000 + w * 16'h100 + c * 2);
                    gl = g; rl = w;
                    new_run(s, d, 6 + g + 2 * w);
                    load(c, s, d);
                    enable();
                    wait_done();
                    chk(widx == c, "R8 sweep writes", widx, c);
                    chk(rdidx == c, "R4 sweep reads", rdidx, c);
                    chk(done_cnt == 1, "R8 sweep done", done_cnt, 1);
                    chk(!bus_req, "R10 bus released", bus_req, 0);
                end
            end
        end

        // R5 one pulse gives one transfer; requests during a transfer are masked
        gl = 0; rl = 0;
        req_n = 1'b1;
        new_run(16'h2000, 16'h3000, 0);
        load(3, 16'h2000, 16'h3000);
        enable();
        idle_cycles(2);
        req_n = 1'b0;
        @(negedge clk);
        req_n = 1'b1;
        idle_cycles(20);
        chk(widx == 1, "R5 one pulse one transfer", widx, 1);
        req_n = 1'b0;              // latched at next edge e0
        @(negedge clk);
        req_n = 1'b1;
        @(negedge clk);            // in activation
        req_n = 1'b0;              // sampled at e2 and e3, both masked
        idle_cycles(2);
        req_n = 1'b1;
        idle_cycles(20);
        chk(widx == 2, "R5 masked during transfer", widx, 2);
        chk(done_cnt == 0, "R8 not yet done", done_cnt, 0);
        req_n = 1'b0;
        @(negedge clk);
        req_n = 1'b1;
        wait_done();
        chk(widx == 3 && done_cnt == 1, "R8 third pulse finishes", widx, 3);

        // R9 load while enabled is ignored
        new_run(16'h4000, 16'h5000, 0);
        load(2, 16'h4000, 16'h5000);
        enable();
        req_n = 1'b0;
        idle_cycles(3);
        load(7, 16'h6000, 16'h7000);
        wait_done();
        chk(widx == 2, "R9 load while enabled", widx, 2);
        req_n = 1'b1;
        idle_cycles(4);
        report();
    end
endmodule